// File: doc/BRIEF.md
# Shared-Port Fetch Controller with Late Redirect

This block owns the program counter of a five-stage in-order pipeline whose instruction fetch and data accesses go through one single-port memory. Every cycle it decides who drives the memory port, whether the PC steps forward, stays put or jumps, and whether the two youngest pipeline slots must be turned into bubbles.

Data accesses from the Mem stage always win the port. In such a cycle no instruction is read, the PC keeps its value and an empty slot (valid low) enters the Fetch/Decode register. Jumps and taken branches are resolved at the end of Execute. A resolved redirect loads the target into the PC and kills the contents of the Fetch/Decode and Decode/Execute registers. A stall request from the decode hazard logic freezes the PC and the Fetch/Decode register, but a redirect overrides it.

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pc_q` equals `BOOT_ADDR` and `fd_valid` is 0. With quiet inputs the first cycle after reset fetches from `BOOT_ADDR`.
- R2: When `dreq_valid` is 1, `mem_cmd` is 2 (load) if `dreq_write` is 0 and 3 (store) if it is 1, and `mem_addr` equals `dreq_addr`, in the same cycle. `mem_cmd` encoding: 0 idle, 1 fetch, 2 load, 3 store.
- R3: In a cycle with a data access and no redirect, no fetch is issued and the PC holds. Without a decode stall, `fd_valid` is 0 on the next cycle.
- R4: When `ex_valid` and `ex_jump` are both 1, `flush_fd` and `flush_de` are 1 in that cycle, no fetch is issued, `pc_q` equals `ex_target` on the next cycle, and `fd_valid` is 0 on the next cycle.
- R5: A branch (`ex_valid`, `ex_branch`) with `ex_taken` 1 behaves as in R4. With `ex_taken` 0 it raises no flush and does not change sequential fetch.
- R6: In a cycle with no data access, redirect or stall, `mem_cmd` is 1 with `mem_addr` equal to `pc_q`, and `fetch_fire` is 1. On the next cycle `pc_q` is the old PC plus `PC_STEP`, `fd_valid` is 1 and `fd_pc` is the fetched address.
- R7: With `dec_stall` 1 and no redirect, no fetch is issued. `pc_q`, `fd_valid` and `fd_pc` hold their values, even if a data access occurs in the same cycle.
- R8: A redirect in the same cycle as `dec_stall` still loads the target and empties Fetch/Decode.
- R9: A redirect in the same cycle as a data access loads the target into the PC while the data access keeps the port. The first fetch from the target follows on the next cycle in which the port is free.
- R10: When `ex_valid` is 0, `ex_jump`, `ex_branch`, `ex_taken` and `ex_target` have no effect on any output.
- R11: `pc_next` always equals the value `pc_q` takes at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq_valid | input | 1 | Mem stage performs a data access this cycle |
| dreq_write | input | 1 | Data access is a store (1) or load (0) |
| dreq_addr | input | 32 | Data access address |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_jump | input | 1 | Execute instruction is an unconditional jump |
| ex_branch | input | 1 | Execute instruction is a conditional branch |
| ex_taken | input | 1 | Branch comparison result |
| ex_target | input | 32 | Redirect target computed in Execute |
| dec_stall | input | 1 | Hold request from the decode hazard logic |
| mem_cmd | output | 2 | Memory command: 0 idle, 1 fetch, 2 load, 3 store |
| mem_addr | output | 32 | Memory address |
| pc_q | output | 32 | Current fetch PC |
| pc_next | output | 32 | PC value after the next edge |
| fetch_fire | output | 1 | An instruction fetch is issued this cycle |
| fd_valid | output | 1 | Fetch/Decode slot holds a live instruction |
| fd_pc | output | 32 | Address of the instruction in Fetch/Decode |
| flush_fd | output | 1 | Kill the Fetch/Decode slot |
| flush_de | output | 1 | Kill the Decode/Execute slot |

## Verification
The assertions assume that the Execute stage never marks one instruction as both a jump and a branch. They also assume that every input is settled before the clock edge that samples it. The bench drives each input just after the falling edge and picks the instruction kind from a single draw, so the jump and branch flags never overlap. Directed sequences place redirects against data accesses and stalls. A long randomized run then mixes all of them, including junk Execute fields while `ex_valid` is low.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int FR_ADDR_W = 32;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_FETCH = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_STORE = 2'd3
    } mem_cmd_e;

    typedef struct packed {
        logic                 valid;
        logic                 write;
        logic [FR_ADDR_W-1:0] addr;
    } data_req_t;

    typedef struct packed {
        logic                 valid;
        logic                 jump;
        logic                 branch;
        logic                 taken;
        logic [FR_ADDR_W-1:0] target;
    } ex_outcome_t;

    // A live jump, or a live branch whose comparison succeeded, redirects.
    function automatic logic wants_redirect(ex_outcome_t ex);
        return ex.valid && (ex.jump || (ex.branch && ex.taken));
    endfunction

    function automatic mem_cmd_e data_cmd(data_req_t dr);
        return dr.write ? CMD_STORE : CMD_LOAD;
    endfunction

endpackage

// File: rtl/fr_redirect_unit.sv
module fr_redirect_unit
    import fr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  ex_outcome_t          ex,
    output logic                 redirect,
    output logic [FR_ADDR_W-1:0] target,
    output logic                 flush_fd,
    output logic                 flush_de
);

    always_comb begin
        redirect = wants_redirect(ex);
        target   = ex.target;
        flush_fd = redirect;
        flush_de = redirect;
    end

    AST_KIND_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        ex.valid |-> $onehot0({ex.jump, ex.branch})); // R4

    AST_JUMP_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        (ex.valid && ex.jump) |-> (flush_fd && flush_de)); // R4

    AST_NOT_TAKEN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ex.valid && ex.branch && !ex.taken) |-> (!flush_fd && !flush_de)); // R5

    AST_IDLE_EX_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ex.valid |-> (!flush_fd && !flush_de)); // R10

endmodule

// File: rtl/fr_port_arbiter.sv
module fr_port_arbiter
    import fr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  data_req_t            dreq,
    input  logic                 fetch_wanted,
    input  logic [FR_ADDR_W-1:0] pc,
    output mem_cmd_e             cmd,
    output logic [FR_ADDR_W-1:0] addr,
    output logic                 fetch_go
);

    always_comb begin
        fetch_go = 1'b0;
        cmd      = CMD_IDLE;
        addr     = pc;
        if (dreq.valid) begin
            cmd  = data_cmd(dreq);
            addr = dreq.addr;
        end else if (fetch_wanted) begin
            fetch_go = 1'b1;
            cmd      = CMD_FETCH;
        end
    end

    AST_DATA_OWNS_PORT: assert property (@(posedge clk) disable iff (rst)
        dreq.valid |-> (!fetch_go && addr == dreq.addr)); // R2

    AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (rst)
        fetch_go |-> (addr == pc && !dreq.valid)); // R6

endmodule

// File: rtl/fr_pc_unit.sv
module fr_pc_unit
    import fr_pkg::*;
#(
    parameter logic [FR_ADDR_W-1:0] BOOT_ADDR = '0,
    parameter int unsigned          PC_STEP   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 redirect,
    input  logic [FR_ADDR_W-1:0] target,
    input  logic                 fetch_go,
    output logic [FR_ADDR_W-1:0] pc_q,
    output logic [FR_ADDR_W-1:0] pc_d
);

    localparam logic [FR_ADDR_W-1:0] STEP = FR_ADDR_W'(PC_STEP);

    always_comb begin
        if (redirect)      pc_d = target;
        else if (fetch_go) pc_d = pc_q + STEP;
        else               pc_d = pc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= BOOT_ADDR;
        else     pc_q <= pc_d;
    end

    AST_PC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!redirect && !fetch_go) |=> $stable(pc_q)); // R3

    AST_PC_TAKES_TARGET: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (pc_q == $past(target))); // R4

    AST_PC_STEPS: assert property (@(posedge clk) disable iff (rst)
        (fetch_go && !redirect) |=> (pc_q == $past(pc_q) + STEP)); // R6

endmodule

// File: rtl/fr_fd_tracker.sv
module fr_fd_tracker
    import fr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 redirect,
    input  logic                 stall,
    input  logic                 fetch_go,
    input  logic [FR_ADDR_W-1:0] pc,
    output logic                 fd_valid,
    output logic [FR_ADDR_W-1:0] fd_pc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fd_valid <= 1'b0;
            fd_pc    <= '0;
        end else if (redirect) begin
            fd_valid <= 1'b0;
        end else if (!stall) begin
            fd_valid <= fetch_go;
            if (fetch_go) fd_pc <= pc;
        end
    end

    AST_FD_KILLED: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !fd_valid); // R8

    AST_FD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (stall && !redirect) |=> ($stable(fd_valid) && $stable(fd_pc))); // R7

    AST_FD_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (!stall && !fetch_go) |=> !fd_valid); // R3

endmodule

// File: rtl/fetch_redirect_ctrl.sv
module fetch_redirect_ctrl
    import fr_pkg::*;
#(
    parameter logic [FR_ADDR_W-1:0] BOOT_ADDR = 32'h0000_1000,
    parameter int unsigned          PC_STEP   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dreq_valid,
    input  logic                 dreq_write,
    input  logic [FR_ADDR_W-1:0] dreq_addr,
    input  logic                 ex_valid,
    input  logic                 ex_jump,
    input  logic                 ex_branch,
    input  logic                 ex_taken,
    input  logic [FR_ADDR_W-1:0] ex_target,
    input  logic                 dec_stall,
    output logic [1:0]           mem_cmd,
    output logic [FR_ADDR_W-1:0] mem_addr,
    output logic [FR_ADDR_W-1:0] pc_q,
    output logic [FR_ADDR_W-1:0] pc_next,
    output logic                 fetch_fire,
    output logic                 fd_valid,
    output logic [FR_ADDR_W-1:0] fd_pc,
    output logic                 flush_fd,
    output logic                 flush_de
);

    data_req_t            dreq;
    ex_outcome_t          ex;
    logic                 redirect;
    logic [FR_ADDR_W-1:0] target;
    logic                 fetch_wanted;
    logic                 fetch_go;
    mem_cmd_e             cmd;

    always_comb begin
        dreq.valid   = dreq_valid;
        dreq.write   = dreq_write;
        dreq.addr    = dreq_addr;
        ex.valid     = ex_valid;
        ex.jump      = ex_jump;
        ex.branch    = ex_branch;
        ex.taken     = ex_taken;
        ex.target    = ex_target;
        // Wrong-path fetches are pointless in a redirect cycle.
        fetch_wanted = !redirect && !dec_stall;
        mem_cmd      = cmd;
        fetch_fire   = fetch_go;
    end

    fr_redirect_unit u_redirect (
        .clk      (clk),
        .rst      (rst),
        .ex       (ex),
        .redirect (redirect),
        .target   (target),
        .flush_fd (flush_fd),
        .flush_de (flush_de)
    );

    fr_port_arbiter u_arbiter (
        .clk          (clk),
        .rst          (rst),
        .dreq         (dreq),
        .fetch_wanted (fetch_wanted),
        .pc           (pc_q),
        .cmd          (cmd),
        .addr         (mem_addr),
        .fetch_go     (fetch_go)
    );

    fr_pc_unit #(
        .BOOT_ADDR (BOOT_ADDR),
        .PC_STEP   (PC_STEP)
    ) u_pc (
        .clk      (clk),
        .rst      (rst),
        .redirect (redirect),
        .target   (target),
        .fetch_go (fetch_go),
        .pc_q     (pc_q),
        .pc_d     (pc_next)
    );

    fr_fd_tracker u_fd (
        .clk      (clk),
        .rst      (rst),
        .redirect (redirect),
        .stall    (dec_stall),
        .fetch_go (fetch_go),
        .pc       (pc_q),
        .fd_valid (fd_valid),
        .fd_pc    (fd_pc)
    );

    AST_NO_FETCH_ON_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        flush_fd |-> !fetch_fire); // R9

    AST_STALL_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        dec_stall |-> !fetch_fire); // R7

    AST_NEXT_MATCHES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc_q == $past(pc_next))); // R11

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pc_q == BOOT_ADDR && !fd_valid)); // R1

endmodule

// File: tb/test_fetch_redirect_ctrl.sv
module test_fetch_redirect_ctrl;

    localparam logic [31:0] BOOT = 32'h0000_1000;
    localparam int          STEP = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        dreq_valid, dreq_write, ex_valid, ex_jump, ex_branch, ex_taken, dec_stall;
    logic [31:0] dreq_addr, ex_target;
    logic [1:0]  mem_cmd;
    logic [31:0] mem_addr, pc_q, pc_next, fd_pc;
    logic        fetch_fire, fd_valid, flush_fd, flush_de;

    always #5 clk = ~clk;

    fetch_redirect_ctrl #(.BOOT_ADDR(BOOT), .PC_STEP(STEP)) i_fetch_redirect_ctrl (
        .clk(clk), .rst(rst),
        .dreq_valid(dreq_valid), .dreq_write(dreq_write), .dreq_addr(dreq_addr),
        .ex_valid(ex_valid), .ex_jump(ex_jump), .ex_branch(ex_branch),
        .ex_taken(ex_taken), .ex_target(ex_target), .dec_stall(dec_stall),
        .mem_cmd(mem_cmd), .mem_addr(mem_addr), .pc_q(pc_q), .pc_next(pc_next),
        .fetch_fire(fetch_fire), .fd_valid(fd_valid), .fd_pc(fd_pc),
        .flush_fd(flush_fd), .flush_de(flush_de)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference state
    longint unsigned m_pc;
    bit              m_fdv;
    longint unsigned m_fdpc;
    string           prev_tag;

    task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(bit dv, bit dw, logic [31:0] da, bit ev, bit ej, bit eb,
                         bit et, logic [31:0] tg, bit st);
        dreq_valid = dv; dreq_write = dw; dreq_addr = da;
        ex_valid = ev; ex_jump = ej; ex_branch = eb; ex_taken = et;
        ex_target = tg; dec_stall = st;
    endtask

    // One cycle: inputs already driven after negedge; check, then advance model.
    task automatic step_cycle();
        bit              redir, fetch;
        int              exp_cmd;
        longint unsigned exp_addr, nxt;
        string           tag;
        #1;
        redir = ex_valid && (ex_jump || (ex_branch && ex_taken));
        fetch = !dreq_valid && !redir && !dec_stall;
        if (redir && dreq_valid)      tag = "R9";
        else if (redir && dec_stall)  tag = "R8";
        else if (redir && ex_jump)    tag = "R4";
        else if (ex_valid && ex_branch) tag = "R5";
        else if (!ex_valid && (ex_jump || ex_branch)) tag = "R10";
        else if (dec_stall)           tag = "R7";
        else if (dreq_valid)          tag = "R3";
        else                          tag = "R6";

        // registered outputs reflect previous cycle
        chk(prev_tag, "pc_q", pc_q, m_pc);
        chk(prev_tag, "fd_valid", fd_valid, m_fdv);
        if (m_fdv) chk(prev_tag, "fd_pc", fd_pc, m_fdpc);

        if (dreq_valid) begin
            exp_cmd = dreq_write ? 3 : 2;
            exp_addr = dreq_addr;
            chk("R2", "mem_cmd", mem_cmd, exp_cmd);
            chk("R2", "mem_addr", mem_addr, exp_addr);
        end else begin
            exp_cmd = fetch ? 1 : 0;
            chk(tag, "mem_cmd", mem_cmd, exp_cmd);
            if (fetch) chk(tag, "mem_addr", mem_addr, m_pc);
        end
        chk(tag, "fetch_fire", fetch_fire, fetch);
        chk(tag, "flush_fd", flush_fd, redir);
        chk(tag, "flush_de", flush_de, redir);

        nxt = redir ? ex_target : (fetch ? (m_pc + STEP) & 32'hFFFF_FFFF : m_pc);
        chk("R11", "pc_next", pc_next, nxt);

        if (redir) m_fdv = 0;
        else if (!dec_stall) begin
            m_fdv = fetch;
            if (fetch) m_fdpc = m_pc;
        end
        m_pc = nxt;
        prev_tag = tag;
        @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1", "pc_q in reset", pc_q, BOOT);
        chk("R1", "fd_valid in reset", fd_valid, 0);
        rst = 0;
        m_pc = BOOT; m_fdv = 0; m_fdpc = 0; prev_tag = "R1";
        #1;
        chk("R1", "first fetch cmd", mem_cmd, 1);
        chk("R1", "first fetch addr", mem_addr, BOOT);
        #1;

        // Directed: sequential, load, store, jump, branch taken/not taken
        step_cycle();                                              // R6
        step_cycle();
        drive(1, 0, 32'h8000, 0, 0, 0, 0, 0, 0); step_cycle();    // R3 load
        drive(1, 1, 32'h8004, 0, 0, 0, 0, 0, 0); step_cycle();    // R2 store
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);        step_cycle();
        drive(0, 0, 0, 1, 1, 0, 0, 32'h2000, 0); step_cycle();    // R4 jump
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);        step_cycle();
        drive(0, 0, 0, 1, 0, 1, 1, 32'h3000, 0); step_cycle();    // R5 taken
        drive(0, 0, 0, 1, 0, 1, 0, 32'h4000, 0); step_cycle();    // R5 not taken
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1);        step_cycle();    // R7 stall
        drive(1, 0, 32'h9000, 0, 0, 0, 0, 0, 1); step_cycle();    // R7 stall + data
        drive(0, 0, 0, 1, 1, 0, 0, 32'h5000, 1); step_cycle();    // R8
        drive(1, 1, 32'hA000, 1, 1, 0, 0, 32'h6000, 0); step_cycle(); // R9
        drive(1, 0, 32'hA004, 0, 0, 0, 0, 0, 0); step_cycle();    // R9 port still busy
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);        step_cycle();    // first target fetch
        drive(0, 0, 0, 0, 1, 1, 1, 32'h7000, 0); step_cycle();    // R10 junk
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);        step_cycle();

        // Randomized mix
        for (int i = 0; i < 3000; i++) begin
            int kind = $urandom_range(0, 5);
            bit dv = ($urandom_range(0, 9) < 3);
            bit ev = ($urandom_range(0, 9) < 4);
            drive(dv, 1'($urandom_range(0, 1)), {$urandom_range(0, 32'hFFFF), 2'b00} ,
                  ev, kind == 0, kind == 1 || kind == 2, kind == 1 || kind == 5,
                  {$urandom_range(0, 32'h3FFF), 2'b00}, ($urandom_range(0, 9) < 2));
            step_cycle();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule